// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block turns 32-bit virtual addresses into physical addresses using 4 KB pages. Every entry pairs a virtual page tag with a physical frame number, a valid bit and a writable bit. The tags sit in registers, and every tag has its own comparator, so all entries are searched in the same cycle. A lowest-index-first priority encoder reduces the match vector to one entry number. That number addresses a frame memory with a registered read port. A translation is therefore ready one clock after it is requested. Addresses whose two top bits are both set are not translated: the block clears those two bits and passes the rest through.

A 3-bit operation code drives the block. The processor keeps three translation registers: an index, a tag word and a frame word. The block receives their present values, and it returns a write strobe and a new value for each one. Using these, software can search for a tag, read an entry, write an entry at a chosen index, or write an entry at an index chosen by the block. That index comes from a down counter. The counter steps only on translation requests, and it never selects the low, wired entries.

Top module: `xlat_cache`

## Requirements
- R1: Reset is asynchronous and active low, and its release is synchronised inside the block. After reset, all four fault flags and all three write strobes are low, and the replacement counter holds ENTRIES-1.
- R2: Operation code 1 (map) with a matching valid, writable entry behaves as follows. From the next clock, `paddr` is the stored frame number (bits 31:12) joined to the page offset `vaddr[11:0]`, and all fault flags are low.
- R3: On a map that hits, `fault_inv` rises the next cycle when the stored valid bit (frame word bit 0) is 0. `fault_wp` rises the next cycle when the stored writable bit (frame word bit 1) is 0. Neither flag is ever high together with a miss flag.
- R4: On a map that matches no entry, the next cycle shows `miss_kern` if `vaddr[31]` was 1, or `miss_user` if it was 0. The two are never high together.
- R5: On a map of an address with `vaddr[31:30]` = 2'b11, the next cycle shows `paddr` equal to `vaddr` with bits 31:30 cleared, and all four fault flags are low.
- R6: When several entries hold the same tag, the lowest-numbered entry is the one used, both for map and for probe.
- R7: Operation code 2 (probe) searches for the tag in `hi_old[31:12]`. In the same cycle it raises `idx_we` and drives `idx_new` with the matching entry number. On a miss, `idx_new` is instead 32'h8000_0000.
- R8: Operation code 5 (write at index) stores the tag `hi_old[31:12]` and the frame word (`lo_old[31:12]`, `lo_old[1]`, `lo_old[0]`) into the entry selected by `idx_old[IDX_W-1:0]`.
- R9: Operation code 3 (write at random index) stores the same tag and frame word into the entry the replacement counter points to. The counter goes down by one on each map operation. From WIRED it wraps to ENTRIES-1. No other operation changes it.
- R10: The frame memory reads `idx_old` on every cycle that does not hold a translation. So when code 4 (read) is applied for two cycles with `idx_old` held, the second cycle raises `hi_we` and `lo_we`. In that cycle `hi_new` is {tag, 12'h0} and `lo_new` is {frame, 10'h0, writable, valid} of that entry.
- R11: Operation code 0 (hold) that follows a map keeps `paddr` and the fault flags unchanged.
- R12: Write strobes appear only for probe (`idx_we`) and read (`hi_we`, `lo_we`). Every other operation leaves all three low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation: 0 hold, 1 map, 2 probe, 3 write random, 4 read, 5 write at index |
| vaddr | input | 32 | Virtual address to translate |
| idx_old | input | 32 | Present index register value |
| hi_old | input | 32 | Present tag register value |
| lo_old | input | 32 | Present frame register value |
| idx_we | output | 1 | Index register write strobe |
| idx_new | output | 32 | New index register value |
| hi_we | output | 1 | Tag register write strobe |
| hi_new | output | 32 | New tag register value |
| lo_we | output | 1 | Frame register write strobe |
| lo_new | output | 32 | New frame register value |
| paddr | output | 32 | Translated physical address |
| miss_kern | output | 1 | Miss on an address with bit 31 set |
| miss_user | output | 1 | Miss on an address with bit 31 clear |
| fault_inv | output | 1 | Hit on an entry marked not valid |
| fault_wp | output | 1 | Hit on an entry marked not writable |

## Verification
The bench builds the block with 8 entries and 2 wired entries. This small configuration lets every entry be filled, probed, translated and read back one by one. Its replacement range is only six entries, so a dozen random writes pass through the counter wrap several times. Each entry's expected frame, flags and index are derived from its number. A bench-side count of map requests predicts where every random write lands.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_MAP   = 3'd1,
    OP_PROBE = 3'd2,
    OP_WRAND = 3'd3,
    OP_READ  = 3'd4,
    OP_WIDX  = 3'd5
  } xlat_op_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 32,
  parameter int PN_W    = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PN_W-1:0]  wr_pn,
  input  logic [PN_W-1:0]  look_pn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PN_W-1:0]  rd_pn,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [PN_W-1:0]    tag_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic tag_en;
    assign tag_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q[g] <= '0;
      else if (tag_en) tag_q[g] <= wr_pn;
    end
    assign match[g] = (tag_q[g] == look_pn);
  end

  // lowest matching entry wins
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit   = |match;
  assign rd_pn = tag_q[rd_idx];
endmodule

// File: rtl/xlat_frame_ram.sv
module xlat_frame_ram #(
  parameter int ENTRIES = 32,
  parameter int DW      = 22,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/xlat_rand.sv
module xlat_rand #(
  parameter int ENTRIES = 32,
  parameter int WIRED   = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] value
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] BOT = IDX_W'(WIRED);

  logic [IDX_W-1:0] val_d, val_q;

  always_comb begin
    val_d = val_q;
    if (step) val_d = (val_q == BOT) ? TOP : val_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= TOP;
    else        val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 32,
  parameter int WIRED     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op,
  input  logic [VA_W-1:0] vaddr,
  input  logic [VA_W-1:0] idx_old,
  input  logic [VA_W-1:0] hi_old,
  input  logic [VA_W-1:0] lo_old,
  output logic            idx_we,
  output logic [VA_W-1:0] idx_new,
  output logic            hi_we,
  output logic [VA_W-1:0] hi_new,
  output logic            lo_we,
  output logic [VA_W-1:0] lo_new,
  output logic [VA_W-1:0] paddr,
  output logic            miss_kern,
  output logic            miss_user,
  output logic            fault_inv,
  output logic            fault_wp
);
  import xlat_pkg::*;

  localparam int PN_W  = VA_W - PAGE_BITS;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int DW    = PN_W + 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // operation decode
  logic is_hold, is_map, is_probe, is_wrand, is_read, is_widx;
  assign is_hold  = (op == OP_HOLD);
  assign is_map   = (op == OP_MAP);
  assign is_probe = (op == OP_PROBE);
  assign is_wrand = (op == OP_WRAND);
  assign is_read  = (op == OP_READ);
  assign is_widx  = (op == OP_WIDX);

  logic [IDX_W-1:0] rnd_idx, sel_idx, wr_idx, hit_idx, rd_idx;
  logic [PN_W-1:0]  look_pn, tag_rd;
  logic             hit, wr_en, rd_en, direct;
  logic [DW-1:0]    ram_q;

  assign sel_idx = idx_old[IDX_W-1:0];
  assign look_pn = is_probe ? hi_old[VA_W-1:PAGE_BITS] : vaddr[VA_W-1:PAGE_BITS];
  assign wr_en   = is_wrand | is_widx;
  assign wr_idx  = is_wrand ? rnd_idx : sel_idx;
  assign direct  = &vaddr[VA_W-1 -: 2];

  // translation stage registers
  logic                map_q, direct_q, hit_q, kern_q;
  logic [VA_W-3:0]     low_q;
  logic                map_d, direct_d, hit_d, kern_d;
  logic [VA_W-3:0]     low_d;
  logic                stage_en;

  assign stage_en = ~is_hold;
  assign rd_en    = ~(is_hold & map_q);
  assign rd_idx   = is_map ? hit_idx : sel_idx;

  always_comb begin
    map_d    = map_q;
    direct_d = direct_q;
    hit_d    = hit_q;
    kern_d   = kern_q;
    low_d    = low_q;
    if (stage_en) begin
      map_d    = is_map;
      direct_d = direct;
      hit_d    = hit;
      kern_d   = vaddr[VA_W-1];
      low_d    = vaddr[VA_W-3:0];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      map_q    <= 1'b0;
      direct_q <= 1'b0;
      hit_q    <= 1'b0;
      kern_q   <= 1'b0;
      low_q    <= '0;
    end else begin
      map_q    <= map_d;
      direct_q <= direct_d;
      hit_q    <= hit_d;
      kern_q   <= kern_d;
      low_q    <= low_d;
    end
  end

  xlat_cam #(.ENTRIES(ENTRIES), .PN_W(PN_W), .IDX_W(IDX_W)) u_cam (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_pn   (hi_old[VA_W-1:PAGE_BITS]),
    .look_pn (look_pn),
    .rd_idx  (sel_idx),
    .rd_pn   (tag_rd),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  xlat_frame_ram #(.ENTRIES(ENTRIES), .DW(DW), .IDX_W(IDX_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data ({lo_old[VA_W-1:PAGE_BITS], lo_old[1], lo_old[0]}),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_data (ram_q)
  );

  xlat_rand #(.ENTRIES(ENTRIES), .WIRED(WIRED), .IDX_W(IDX_W)) u_rand (
    .clk   (clk),
    .rst_n (srst_n),
    .step  (is_map),
    .value (rnd_idx)
  );

  // translated outputs
  logic live;
  assign live      = map_q & ~direct_q;
  assign paddr     = direct_q ? {2'b00, low_q}
                              : {ram_q[DW-1:2], low_q[PAGE_BITS-1:0]};
  assign miss_kern = live & ~hit_q &  kern_q;
  assign miss_user = live & ~hit_q & ~kern_q;
  assign fault_inv = live &  hit_q & ~ram_q[0];
  assign fault_wp  = live &  hit_q & ~ram_q[1];

  // register write-back
  assign idx_we  = is_probe;
  assign idx_new = hit ? {{(VA_W-IDX_W){1'b0}}, hit_idx} : {1'b1, {(VA_W-1){1'b0}}};
  assign hi_we   = is_read;
  assign hi_new  = {tag_rd, {PAGE_BITS{1'b0}}};
  assign lo_we   = is_read;
  assign lo_new  = {ram_q[DW-1:2], {(PAGE_BITS-2){1'b0}}, ram_q[1], ram_q[0]};

  logic unused_bits;
  assign unused_bits = ^{idx_old[VA_W-1:IDX_W], hi_old[PAGE_BITS-1:0],
                         lo_old[PAGE_BITS-1:2]};
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VA_W    = 32,
  parameter int ENTRIES = 32,
  parameter int WIRED   = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             srst_n,
  input logic [2:0]       op,
  input logic [VA_W-1:0]  vaddr,
  input logic [VA_W-1:0]  paddr,
  input logic             miss_kern,
  input logic             miss_user,
  input logic             fault_inv,
  input logic             fault_wp,
  input logic             idx_we,
  input logic             hi_we,
  input logic             lo_we,
  input logic [IDX_W-1:0] rnd
);
  AST_RAND_RANGE: assert property (@(posedge clk) disable iff (!srst_n)
    (int'(rnd) >= WIRED) && (int'(rnd) < ENTRIES)); // R9
  AST_RAND_STILL: assert property (@(posedge clk) disable iff (!srst_n)
    (op != 3'd1) |=> $stable(rnd)); // R9
  AST_RAND_WRAP: assert property (@(posedge clk) disable iff (!srst_n)
    (op == 3'd1 && int'(rnd) == WIRED) |=> (int'(rnd) == ENTRIES - 1)); // R9
  AST_DIRECT_CLEAN: assert property (@(posedge clk) disable iff (!srst_n)
    (op == 3'd1 && (&vaddr[VA_W-1 -: 2])) |=>
      !(miss_kern || miss_user || fault_inv || fault_wp)); // R5
  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!srst_n)
    (op == 3'd1 && (&vaddr[VA_W-1 -: 2])) |=>
      (paddr[VA_W-1 -: 2] == 2'b00) && (paddr[VA_W-3:0] == $past(vaddr[VA_W-3:0]))); // R5
  AST_MISS_SPLIT: assert property (@(posedge clk) disable iff (!srst_n)
    !(miss_kern && miss_user)); // R4
  AST_MISS_NO_FAULT: assert property (@(posedge clk) disable iff (!srst_n)
    (miss_kern || miss_user) |-> !(fault_inv || fault_wp)); // R3
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    !(op == 3'd2 || op == 3'd4) |-> !(idx_we || hi_we || lo_we)); // R12
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!srst_n)
    (op == 3'd0 && $past(op) == 3'd1) |=> $stable(paddr)); // R11
endmodule

bind xlat_cache xlat_cache_chk #(
  .VA_W(VA_W), .ENTRIES(ENTRIES), .WIRED(WIRED), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .op        (op),
  .vaddr     (vaddr),
  .paddr     (paddr),
  .miss_kern (miss_kern),
  .miss_user (miss_user),
  .fault_inv (fault_inv),
  .fault_wp  (fault_wp),
  .idx_we    (idx_we),
  .hi_we     (hi_we),
  .lo_we     (lo_we),
  .rnd       (rnd_idx)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  localparam int ENT = 8;
  localparam int WIR = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic [31:0] vaddr, idx_old, hi_old, lo_old;
  logic        idx_we, hi_we, lo_we;
  logic [31:0] idx_new, hi_new, lo_new, paddr;
  logic        miss_kern, miss_user, fault_inv, fault_wp;

  always #4 clk = ~clk;

  xlat_cache #(.VA_W(32), .PAGE_BITS(12), .ENTRIES(ENT), .WIRED(WIR)) i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .op(op), .vaddr(vaddr),
    .idx_old(idx_old), .hi_old(hi_old), .lo_old(lo_old),
    .idx_we(idx_we), .idx_new(idx_new), .hi_we(hi_we), .hi_new(hi_new),
    .lo_we(lo_we), .lo_new(lo_new), .paddr(paddr),
    .miss_kern(miss_kern), .miss_user(miss_user),
    .fault_inv(fault_inv), .fault_wp(fault_wp)
  );

  int n_chk = 0;
  int n_fail = 0;
  int rmodel;
  bit done = 1'b0;

  function automatic logic [19:0] pg(input int i);
    return 20'h00100 + 20'(i);
  endfunction
  function automatic logic [19:0] fr(input int i);
    return 20'h00A00 + 20'(3 * i);
  endfunction
  function automatic logic vb(input int i);
    return i != 5;
  endfunction
  function automatic logic wb(input int i);
    return i != 6;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic widx(input int i, input logic [19:0] p, input logic [19:0] f,
                      input logic w, input logic v);
    idx_old = 32'(i); hi_old = {p, 12'h0}; lo_old = {f, 10'h0, w, v};
    op = 3'd5; #1;
    chk("R12 widx strobes", {29'h0, idx_we, hi_we, lo_we}, 32'h0);
    tick; op = 3'd0;
  endtask

  task automatic probe(input string req, input logic [19:0] p, input logic [31:0] exp);
    hi_old = {p, 12'h0}; op = 3'd2; #1;
    chk({req, " probe strobe"}, {31'h0, idx_we}, 32'h1);
    chk({req, " probe index"}, idx_new, exp);
    tick; op = 3'd0;
  endtask

  task automatic map(input logic [31:0] va);
    vaddr = va; op = 3'd1; #1;
    chk("R12 map strobes", {29'h0, idx_we, hi_we, lo_we}, 32'h0);
    tick; op = 3'd0;
    rmodel = (rmodel == WIR) ? ENT - 1 : rmodel - 1;
    #1;
  endtask

  function automatic logic [31:0] flags;
    return {28'h0, miss_kern, miss_user, fault_inv, fault_wp};
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op = 3'd0; vaddr = '0; idx_old = '0; hi_old = '0; lo_old = '0;
    rmodel = ENT - 1;
    repeat (3) tick;
    rst_n = 1'b1;
    repeat (4) tick;
    #1;
    // R1: quiet outputs after reset
    chk("R1 flags", flags(), 32'h0);
    chk("R1 strobes", {29'h0, idx_we, hi_we, lo_we}, 32'h0);
    // R1 R9: first random write lands at ENTRIES-1
    hi_old = {20'h003FF, 12'h0}; lo_old = 32'h0; op = 3'd3; tick; op = 3'd0;
    probe("R1 R9 reset counter", 20'h003FF, 32'(ENT - 1));

    // R8: fill every entry by index, R7: probe each back
    for (int i = 0; i < ENT; i++) widx(i, pg(i), fr(i), wb(i), vb(i));
    for (int i = 0; i < ENT; i++) probe("R7 R8 hit", pg(i), 32'(i));
    probe("R7 miss", 20'h00777, 32'h8000_0000);

    // R2 R3: translate every entry
    for (int i = 0; i < ENT; i++) begin
      logic [11:0] off;
      off = 12'h123 + 12'(17 * i);
      map({pg(i), off});
      chk("R2 paddr", paddr, {fr(i), off});
      chk("R3 flags", flags(), {30'h0, ~vb(i), ~wb(i)});
    end

    // R11: hold keeps the last translation
    map({pg(6), 12'h0AB});
    tick; tick; #1;
    chk("R11 hold paddr", paddr, {fr(6), 12'h0AB});
    chk("R11 hold flags", flags(), 32'h1);

    // R4: miss split by address bit 31
    map(32'h0000_5123);
    chk("R4 user miss", flags(), 32'h4);
    map(32'h8000_5123);
    chk("R4 kernel miss", flags(), 32'h8);
    map(32'hBFFF_F000);
    chk("R4 kernel miss high", flags(), 32'h8);

    // R5: direct window bypasses lookup
    map(32'hC001_0ABC);
    chk("R5 direct paddr", paddr, 32'h0001_0ABC);
    chk("R5 direct flags", flags(), 32'h0);
    map(32'hFFFF_FFFF);
    chk("R5 direct top", paddr, 32'h3FFF_FFFF);
    chk("R5 direct top flags", flags(), 32'h0);

    // R10: read back every entry
    for (int i = 0; i < ENT; i++) begin
      idx_old = 32'(i); op = 3'd4; tick; #1;
      chk("R10 strobes", {30'h0, hi_we, lo_we}, 32'h3);
      chk("R10 tag", hi_new, {pg(i), 12'h0});
      chk("R10 frame", lo_new, {fr(i), 10'h0, wb(i), vb(i)});
      tick; op = 3'd0;
    end

    // R6: duplicate tag resolves to the lower entry
    widx(7, pg(3), 20'h0FFFF, 1'b1, 1'b1);
    probe("R6 probe", pg(3), 32'd3);
    map({pg(3), 12'h456});
    chk("R6 map", paddr, {fr(3), 12'h456});
    widx(7, pg(7), fr(7), wb(7), vb(7));

    // R9: random writes track the map count and wrap over wired entries
    for (int j = 0; j < 12; j++) begin
      for (int k = 0; k < j % 3; k++) map(32'h0000_9000);
      hi_old = {20'h00300 + 20'(j), 12'h0}; lo_old = {20'h00B00 + 20'(j), 12'h3};
      op = 3'd3; tick; op = 3'd0;
      probe("R9 random slot", 20'h00300 + 20'(j), 32'(rmodel));
    end
    probe("R9 wired entry kept", pg(0), 32'd0);
    probe("R9 wired entry kept", pg(1), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule